// File: doc/BRIEF.md
# Cache Miss Dispatcher with Outstanding-Miss Coalescing

This block sits after a cache's tag lookup and decides, in one cycle, where each request goes. A request that found its line is answered, or quietly dropped when its command expects no answer. A request that missed is compared by line address and secure state against a small file of outstanding-miss entries. It is then merged into a matching entry as an extra target, sent to the write buffer, or given a fresh entry. The tag array, data array, fill logic and downstream memory stay outside and appear only as lookup-result inputs, a retire port and one-cycle routing pulses.

Upstream is stalled by a three-state controller. `ST_RUN` accepts requests. `ST_WAIT_TGT` is entered (transition `fill_targets`) when a merge brings an entry to its target limit, and it leaves (`cause_retired`) only when that entry retires. `ST_WAIT_FREE` is entered (`last_free_taken`) when an allocation uses the last free entry, and it leaves (`any_retired`) on any retire. Every routing output is registered and pulses in the cycle after acceptance. The order tag counts from 0 after reset and steps on each allocation and each merge.

Command encoding on `req_cmd`: 0 read, 1 write, 2 software prefetch, 3 clean eviction, 4 dirty writeback, 5 write-clean, 6 cache maintenance. A line is 64 bytes, so entries compare `req_addr[31:6]`.

Top module: `miss_dispatch`

## Requirements
- R1: After reset `req_ready` is 1, every routing pulse and stall flag is 0, the first allocation uses entry 0 and the first order tag is 0.
- R2: A cacheable lookup hit of a read, write, software prefetch or maintenance command pulses only `resp_valid`. A hit of a clean eviction, dirty writeback or write-clean pulses only `drop_valid`.
- R3: A cacheable read, write or maintenance miss with no matching entry pulses `alloc_valid` with `alloc_idx` set to the lowest free entry and `tgt_order` set to the current order count.
- R4: An entry matches only when `req_addr[31:6]` and `req_secure` both equal the values stored with it. The same line with a different secure bit allocates a new entry.
- R5: An uncacheable request never matches, and a cacheable request never matches an entry allocated uncacheable. An uncacheable read allocates, and an uncacheable write goes to the write buffer (`wb_valid`).
- R6: A software prefetch miss pulses `resp_valid` at once. It also pulses `alloc_valid` only when no entry matches, and it never merges.
- R7: A clean eviction that matches an entry is dropped (`drop_valid`). Without a match it goes to the write buffer. A dirty writeback miss always goes to the write buffer.
- R8: A write-clean miss always goes to the write buffer, whether or not an entry matches.
- R9: Any other miss that matches pulses `coal_valid` with `coal_idx` set to the matching entry. `tgt_order` counts up by one across successive allocations and merges.
- R10: A merge that brings an entry to 4 targets raises `stall_no_targets`, drops `req_ready` and sets `stall_cause` to that entry. Requests offered while stalled produce no pulse. Only a retire of that entry releases the stall.
- R11: An allocation that takes the last free entry raises `stall_no_mshr` and drops `req_ready` until any entry retires. The next allocation then reuses the lowest free entry.
- R12: `clr_readable` pulses only for a cacheable write or maintenance miss that allocates a fresh entry while the resident line is valid and not writable.
- R13: `pf_notify` pulses for every accepted request except software prefetches and maintenance commands, on hits and misses alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_cmd | input | 3 | Command code |
| req_addr | input | 32 | Byte address |
| req_secure | input | 1 | Secure-state bit |
| req_uncacheable | input | 1 | Uncacheable access |
| req_tag_hit | input | 1 | Lookup found the line |
| req_line_valid | input | 1 | Resident line valid |
| req_line_writable | input | 1 | Resident line writable |
| retire_en | input | 1 | An outstanding entry completes |
| retire_idx | input | 2 | Entry that completes |
| resp_valid | output | 1 | Respond to requester |
| drop_valid | output | 1 | Request discarded |
| wb_valid | output | 1 | Send to write buffer |
| alloc_valid | output | 1 | New entry allocated |
| alloc_idx | output | 2 | Allocated entry |
| coal_valid | output | 1 | Merged as extra target |
| coal_idx | output | 2 | Entry merged into |
| tgt_order | output | 8 | Order tag of allocation or merge |
| clr_readable | output | 1 | Clear resident line's readable bit |
| pf_notify | output | 1 | Notify prefetcher |
| stall_no_targets | output | 1 | Stalled on a full target list |
| stall_no_mshr | output | 1 | Stalled with no free entry |
| stall_cause | output | 2 | Entry whose target list is full |

## Verification
The bench goes after the match key: a secure-bit mismatch and an uncacheable entry on the same line must both miss. A design that ignored either would merge where it should allocate, and `coal_valid` would rise in place of `alloc_valid`. The command steering gets its own cases. A clean eviction that hits an entry must be dropped, and a write-clean with a match must still go to the write buffer. A prefetch that repeats must answer without queueing. Getting any of these wrong moves the pulse to another routing output. The stall cases retire an unrelated entry first, so a design that released on any retire would raise `req_ready` too early. They also offer a request while stalled, to show that nothing leaks out.

// File: rtl/miss_dispatch_pkg.sv
package miss_dispatch_pkg;

    typedef enum logic [2:0] {
        CMD_READ        = 3'd0,
        CMD_WRITE       = 3'd1,
        CMD_SWPF        = 3'd2,
        CMD_CLEAN_EVICT = 3'd3,
        CMD_WRITEBACK   = 3'd4,
        CMD_WRITE_CLEAN = 3'd5,
        CMD_MAINT       = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_WAIT_TGT  = 2'd1,
        ST_WAIT_FREE = 2'd2
    } stall_st_e;

    typedef struct packed {
        logic resp;
        logic drop;
        logic wb;
        logic alloc;
        logic coal;
        logic clr_rd;
        logic notify;
    } route_t;

    function automatic logic cmd_wants_resp(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE) || (c == CMD_SWPF) || (c == CMD_MAINT);
    endfunction

endpackage

// File: rtl/md_mshr_file.sv
module md_mshr_file #(
    parameter int N_MSHR = 4,
    parameter int N_TGT  = 4,
    parameter int BLK_W  = 26,
    localparam int IDX_W = $clog2(N_MSHR),
    localparam int CNT_W = $clog2(N_TGT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BLK_W-1:0] lk_blk,
    input  logic             lk_sec,
    input  logic             lk_unc,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [CNT_W-1:0] lk_cnt,
    output logic [IDX_W-1:0] free_idx,
    output logic [IDX_W:0]   free_cnt,
    input  logic             alloc_en,
    input  logic             append_en,
    input  logic [IDX_W-1:0] append_idx,
    input  logic             retire_en,
    input  logic [IDX_W-1:0] retire_idx
);

    logic             valid_q [N_MSHR];
    logic             unc_q   [N_MSHR];
    logic             sec_q   [N_MSHR];
    logic [BLK_W-1:0] blk_q   [N_MSHR];
    logic [CNT_W-1:0] cnt_q   [N_MSHR];

    logic [N_MSHR-1:0] match_v;
    logic [N_MSHR-1:0] free_v;

    // per-entry comparators; an entry retiring this cycle no longer matches
    for (genvar g = 0; g < N_MSHR; g++) begin : g_cmp
        assign match_v[g] = valid_q[g] && !unc_q[g] && (blk_q[g] == lk_blk) &&
                            (sec_q[g] == lk_sec) &&
                            !(retire_en && (retire_idx == IDX_W'(g)));
        assign free_v[g]  = !valid_q[g];
    end

    assign lk_hit   = (|match_v) && !lk_unc;
    assign free_cnt = (IDX_W+1)'($countones(free_v));

    always_comb begin
        lk_idx   = '0;
        free_idx = '0;
        for (int i = N_MSHR - 1; i >= 0; i--) begin
            if (match_v[i]) lk_idx   = IDX_W'(i);
            if (free_v[i])  free_idx = IDX_W'(i);
        end
    end

    assign lk_cnt = cnt_q[lk_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_MSHR; i++) begin
                valid_q[i] <= 1'b0;
                unc_q[i]   <= 1'b0;
                sec_q[i]   <= 1'b0;
                blk_q[i]   <= '0;
                cnt_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < N_MSHR; i++) begin
                if (retire_en && (retire_idx == IDX_W'(i))) begin
                    valid_q[i] <= 1'b0;
                    cnt_q[i]   <= '0;
                end else if (alloc_en && free_v[i] && (free_idx == IDX_W'(i))) begin
                    valid_q[i] <= 1'b1;
                    unc_q[i]   <= lk_unc;
                    sec_q[i]   <= lk_sec;
                    blk_q[i]   <= lk_blk;
                    cnt_q[i]   <= CNT_W'(1);
                end else if (append_en && (append_idx == IDX_W'(i))) begin
                    cnt_q[i]   <= cnt_q[i] + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/md_route_decode.sv
module md_route_decode
    import miss_dispatch_pkg::*;
(
    input  logic   accept,
    input  cmd_e   cmd,
    input  logic   unc,
    input  logic   tag_hit,
    input  logic   line_valid,
    input  logic   line_writable,
    input  logic   mshr_hit,
    output route_t rt
);

    logic miss_path;
    assign miss_path = unc || !tag_hit;

    always_comb begin
        rt = '0;
        if (accept) begin
            rt.notify = (cmd != CMD_SWPF) && (cmd != CMD_MAINT);
            if (!miss_path) begin
                if (cmd_wants_resp(cmd)) rt.resp = 1'b1;
                else                     rt.drop = 1'b1;
            end else begin
                unique case (cmd)
                    CMD_SWPF: begin
                        rt.resp  = 1'b1;
                        rt.alloc = !mshr_hit;
                    end
                    CMD_CLEAN_EVICT: begin
                        if (mshr_hit) rt.drop = 1'b1;
                        else          rt.wb   = 1'b1;
                    end
                    CMD_WRITEBACK, CMD_WRITE_CLEAN: begin
                        rt.wb = 1'b1;
                    end
                    default: begin
                        if (mshr_hit)                         rt.coal  = 1'b1;
                        else if (unc && (cmd == CMD_WRITE))   rt.wb    = 1'b1;
                        else                                  rt.alloc = 1'b1;
                        rt.clr_rd = !mshr_hit && !unc && line_valid && !line_writable &&
                                    ((cmd == CMD_WRITE) || (cmd == CMD_MAINT));
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/md_stall_fsm.sv
module md_stall_fsm
    import miss_dispatch_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_targets,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             last_free_taken,
    input  logic             retire_en,
    input  logic [IDX_W-1:0] retire_idx,
    output logic             ready,
    output logic             stall_tgt,
    output logic             stall_free,
    output logic [IDX_W-1:0] cause_idx
);

    stall_st_e        state_q, state_d;
    logic [IDX_W-1:0] cause_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            if (fill_targets) cause_q <= fill_idx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fill_targets)         state_d = ST_WAIT_TGT;
                else if (last_free_taken) state_d = ST_WAIT_FREE;
            end
            ST_WAIT_TGT: begin
                if (retire_en && (retire_idx == cause_q)) state_d = ST_RUN;
            end
            ST_WAIT_FREE: begin
                if (retire_en) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        ready      = (state_q == ST_RUN);
        stall_tgt  = (state_q == ST_WAIT_TGT);
        stall_free = (state_q == ST_WAIT_FREE);
        cause_idx  = cause_q;
    end

endmodule

// File: rtl/miss_dispatch.sv
module miss_dispatch
    import miss_dispatch_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int N_MSHR     = 4,
    parameter int N_TGT      = 4,
    parameter int ORD_W      = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int BLK_W     = ADDR_W - OFF_W,
    localparam int IDX_W     = $clog2(N_MSHR),
    localparam int CNT_W     = $clog2(N_TGT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_secure,
    input  logic              req_uncacheable,
    input  logic              req_tag_hit,
    input  logic              req_line_valid,
    input  logic              req_line_writable,
    input  logic              retire_en,
    input  logic [IDX_W-1:0]  retire_idx,
    output logic              resp_valid,
    output logic              drop_valid,
    output logic              wb_valid,
    output logic              alloc_valid,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              coal_valid,
    output logic [IDX_W-1:0]  coal_idx,
    output logic [ORD_W-1:0]  tgt_order,
    output logic              clr_readable,
    output logic              pf_notify,
    output logic              stall_no_targets,
    output logic              stall_no_mshr,
    output logic [IDX_W-1:0]  stall_cause
);

    logic             accept;
    logic             lk_hit;
    logic [IDX_W-1:0] lk_idx;
    logic [CNT_W-1:0] lk_cnt;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W:0]   free_cnt;
    route_t           rt;
    logic             fill_targets;
    logic             last_free_taken;
    logic [ORD_W-1:0] ord_q;
    logic             unused_low_addr;

    assign unused_low_addr = ^req_addr[OFF_W-1:0];
    assign accept = req_valid && req_ready;

    md_mshr_file #(
        .N_MSHR (N_MSHR),
        .N_TGT  (N_TGT),
        .BLK_W  (BLK_W)
    ) u_mshr (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_blk     (req_addr[ADDR_W-1:OFF_W]),
        .lk_sec     (req_secure),
        .lk_unc     (req_uncacheable),
        .lk_hit     (lk_hit),
        .lk_idx     (lk_idx),
        .lk_cnt     (lk_cnt),
        .free_idx   (free_idx),
        .free_cnt   (free_cnt),
        .alloc_en   (rt.alloc),
        .append_en  (rt.coal),
        .append_idx (lk_idx),
        .retire_en  (retire_en),
        .retire_idx (retire_idx)
    );

    md_route_decode u_dec (
        .accept        (accept),
        .cmd           (cmd_e'(req_cmd)),
        .unc           (req_uncacheable),
        .tag_hit       (req_tag_hit),
        .line_valid    (req_line_valid),
        .line_writable (req_line_writable),
        .mshr_hit      (lk_hit),
        .rt            (rt)
    );

    assign fill_targets    = rt.coal && (lk_cnt == CNT_W'(N_TGT - 1));
    assign last_free_taken = rt.alloc && (free_cnt == (IDX_W+1)'(1)) && !retire_en;

    md_stall_fsm #(
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .fill_targets    (fill_targets),
        .fill_idx        (lk_idx),
        .last_free_taken (last_free_taken),
        .retire_en       (retire_en),
        .retire_idx      (retire_idx),
        .ready           (req_ready),
        .stall_tgt       (stall_no_targets),
        .stall_free      (stall_no_mshr),
        .cause_idx       (stall_cause)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            drop_valid   <= 1'b0;
            wb_valid     <= 1'b0;
            alloc_valid  <= 1'b0;
            alloc_idx    <= '0;
            coal_valid   <= 1'b0;
            coal_idx     <= '0;
            tgt_order    <= '0;
            clr_readable <= 1'b0;
            pf_notify    <= 1'b0;
            ord_q        <= '0;
        end else begin
            resp_valid   <= rt.resp;
            drop_valid   <= rt.drop;
            wb_valid     <= rt.wb;
            alloc_valid  <= rt.alloc;
            coal_valid   <= rt.coal;
            clr_readable <= rt.clr_rd;
            pf_notify    <= rt.notify;
            if (rt.alloc) alloc_idx <= free_idx;
            if (rt.coal)  coal_idx  <= lk_idx;
            if (rt.alloc || rt.coal) begin
                tgt_order <= ord_q;
                ord_q     <= ord_q + ORD_W'(1);
            end
        end
    end

endmodule

// File: rtl/miss_dispatch_chk.sv
module miss_dispatch_chk #(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_cmd,
    input logic             req_uncacheable,
    input logic             retire_en,
    input logic [IDX_W-1:0] retire_idx,
    input logic             resp_valid,
    input logic             drop_valid,
    input logic             wb_valid,
    input logic             alloc_valid,
    input logic             coal_valid,
    input logic             clr_readable,
    input logic             pf_notify,
    input logic             stall_no_targets,
    input logic             stall_no_mshr,
    input logic [IDX_W-1:0] stall_cause
);

    assert_out_needs_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid || drop_valid || wb_valid || alloc_valid || coal_valid) |->
        $past(req_valid && req_ready));

    assert_one_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drop_valid, wb_valid, alloc_valid, coal_valid}));

    assert_tgt_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_no_targets && !(retire_en && retire_idx == stall_cause)) |=> stall_no_targets);

    assert_free_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_no_mshr && !retire_en) |=> stall_no_mshr);

    assert_clr_cacheable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_readable |-> ($past(!req_uncacheable) && alloc_valid));

    assert_notify_kind_R13: assert property (@(posedge clk) disable iff (!rst_n)
        pf_notify |-> $past(req_valid && req_ready && req_cmd != 3'd2 && req_cmd != 3'd6));

endmodule

bind miss_dispatch miss_dispatch_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/miss_dispatch_tb.sv
module miss_dispatch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic        req_secure = 1'b0;
    logic        req_uncacheable = 1'b0;
    logic        req_tag_hit = 1'b0;
    logic        req_line_valid = 1'b0;
    logic        req_line_writable = 1'b0;
    logic        retire_en = 1'b0;
    logic [1:0]  retire_idx = '0;
    logic        resp_valid, drop_valid, wb_valid, alloc_valid, coal_valid;
    logic [1:0]  alloc_idx, coal_idx, stall_cause;
    logic [7:0]  tgt_order;
    logic        clr_readable, pf_notify, stall_no_targets, stall_no_mshr;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    miss_dispatch u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_secure(req_secure),
        .req_uncacheable(req_uncacheable), .req_tag_hit(req_tag_hit),
        .req_line_valid(req_line_valid), .req_line_writable(req_line_writable),
        .retire_en(retire_en), .retire_idx(retire_idx),
        .resp_valid(resp_valid), .drop_valid(drop_valid), .wb_valid(wb_valid),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx), .coal_valid(coal_valid),
        .coal_idx(coal_idx), .tgt_order(tgt_order), .clr_readable(clr_readable),
        .pf_notify(pf_notify), .stall_no_targets(stall_no_targets),
        .stall_no_mshr(stall_no_mshr), .stall_cause(stall_cause)
    );

    localparam logic [2:0] RD = 3'd0, WR = 3'd1, PF = 3'd2, CE = 3'd3,
                           WB = 3'd4, WCL = 3'd5, MT = 3'd6;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] route();
        return {resp_valid, drop_valid, wb_valid, alloc_valid, coal_valid};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [2:0] cmd, input logic [31:0] addr, input logic sec,
                        input logic unc, input logic hit, input logic lv, input logic lw);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_secure = sec;
        req_uncacheable = unc; req_tag_hit = hit; req_line_valid = lv; req_line_writable = lw;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic retire(input logic [1:0] idx);
        @(negedge clk);
        retire_en = 1'b1; retire_idx = idx;
        @(negedge clk);
        retire_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 ready after reset", req_ready, 1);
        check("R1 pulses after reset", {route(), clr_readable, pf_notify}, 0);
        check("R1 stalls after reset", {stall_no_targets, stall_no_mshr}, 0);
    endtask

    task automatic t_hits();
        do_reset();
        send(RD, 32'h100, 0, 0, 1, 1, 1);
        check("R2 read hit route", route(), 5'b10000);
        check("R13 read hit notify", pf_notify, 1);
        send(WB, 32'h100, 0, 0, 1, 1, 1);
        check("R2 writeback hit route", route(), 5'b01000);
        send(WCL, 32'h100, 0, 0, 1, 1, 1);
        check("R2 write-clean hit route", route(), 5'b01000);
        send(PF, 32'h100, 0, 0, 1, 1, 1);
        check("R2 prefetch hit route", route(), 5'b10000);
        check("R13 prefetch no notify", pf_notify, 0);
    endtask

    task automatic t_alloc_match();
        do_reset();
        send(RD, 32'h1000, 0, 0, 0, 0, 0);
        check("R3 first alloc route", route(), 5'b00010);
        check("R1 first alloc idx", alloc_idx, 0);
        check("R1 first order", tgt_order, 0);
        send(WR, 32'h2000, 0, 0, 0, 0, 0);
        check("R3 second alloc idx", alloc_idx, 1);
        check("R9 order after alloc", tgt_order, 1);
        send(RD, 32'h1010, 0, 0, 0, 0, 0);
        check("R9 same line coalesces", route(), 5'b00001);
        check("R9 coal idx", coal_idx, 0);
        check("R9 coal order", tgt_order, 2);
        send(RD, 32'h1000, 1, 0, 0, 0, 0);
        check("R4 secure mismatch allocates", route(), 5'b00010);
        check("R4 secure alloc idx", alloc_idx, 2);
        check("R9 order increments", tgt_order, 3);
    endtask

    task automatic t_uncacheable();
        do_reset();
        send(RD, 32'h3000, 0, 0, 0, 0, 0);
        send(RD, 32'h3000, 0, 1, 0, 0, 0);
        check("R5 uncacheable read allocates", route(), 5'b00010);
        check("R5 uncacheable alloc idx", alloc_idx, 1);
        send(RD, 32'h3000, 0, 0, 0, 0, 0);
        check("R5 cacheable picks cacheable entry", {route(), 3'b000, coal_idx}, {5'b00001, 3'b000, 2'd0});
        send(WR, 32'h3000, 0, 1, 0, 0, 0);
        check("R5 uncacheable write to wb", route(), 5'b00100);
    endtask

    task automatic t_prefetch_evict();
        do_reset();
        send(PF, 32'h4000, 0, 0, 0, 0, 0);
        check("R6 prefetch miss resp+alloc", route(), 5'b10010);
        check("R13 prefetch miss no notify", pf_notify, 0);
        send(PF, 32'h4000, 0, 0, 0, 0, 0);
        check("R6 repeated prefetch resp only", route(), 5'b10000);
        send(CE, 32'h4000, 0, 0, 0, 0, 0);
        check("R7 clean evict match drops", route(), 5'b01000);
        check("R13 clean evict notifies", pf_notify, 1);
        send(CE, 32'h5000, 0, 0, 0, 0, 0);
        check("R7 clean evict no match wb", route(), 5'b00100);
        send(WB, 32'h4000, 0, 0, 0, 0, 0);
        check("R7 writeback miss wb", route(), 5'b00100);
        send(WCL, 32'h4000, 0, 0, 0, 0, 0);
        check("R8 write-clean with match wb", route(), 5'b00100);
        send(WCL, 32'h6000, 0, 0, 0, 0, 0);
        check("R8 write-clean no match wb", route(), 5'b00100);
    endtask

    task automatic t_target_full();
        do_reset();
        send(RD, 32'h6000, 0, 0, 0, 0, 0);
        send(RD, 32'h7000, 0, 0, 0, 0, 0);
        send(RD, 32'h6000, 0, 0, 0, 0, 0);
        send(RD, 32'h6004, 0, 0, 0, 0, 0);
        check("R10 ready below limit", req_ready, 1);
        send(RD, 32'h6008, 0, 0, 0, 0, 0);
        check("R10 last merge accepted", coal_valid, 1);
        check("R10 stall raised", {stall_no_targets, req_ready}, 2'b10);
        check("R10 stall cause", stall_cause, 0);
        send(RD, 32'h9000, 0, 0, 0, 0, 0);
        check("R10 stalled request ignored", {route(), pf_notify}, 0);
        retire(2'd1);
        check("R10 other retire keeps stall", {stall_no_targets, req_ready}, 2'b10);
        retire(2'd0);
        check("R10 cause retire releases", {stall_no_targets, req_ready}, 2'b01);
    endtask

    task automatic t_all_used();
        do_reset();
        send(RD, 32'h10000, 0, 0, 0, 0, 0);
        send(RD, 32'h20000, 0, 0, 0, 0, 0);
        send(RD, 32'h30000, 0, 0, 0, 0, 0);
        check("R11 ready with one free", req_ready, 1);
        send(RD, 32'h40000, 0, 0, 0, 0, 0);
        check("R11 last entry idx", alloc_idx, 3);
        check("R11 full stall", {stall_no_mshr, req_ready}, 2'b10);
        retire(2'd2);
        check("R11 retire releases", {stall_no_mshr, req_ready}, 2'b01);
        send(RD, 32'h50000, 0, 0, 0, 0, 0);
        check("R11 reuse lowest free", {alloc_valid, 1'b0, alloc_idx}, {1'b1, 1'b0, 2'd2});
        check("R11 stall again", stall_no_mshr, 1);
    endtask

    task automatic t_readable();
        do_reset();
        send(WR, 32'h8000, 0, 0, 0, 1, 0);
        check("R12 write miss valid non-writable clears", {clr_readable, alloc_valid}, 2'b11);
        check("R13 write miss notifies", pf_notify, 1);
        send(WR, 32'h9000, 0, 0, 0, 0, 0);
        check("R12 invalid line no clear", clr_readable, 0);
        send(RD, 32'hA000, 0, 0, 0, 1, 0);
        check("R12 read miss no clear", clr_readable, 0);
        send(WR, 32'h8000, 0, 0, 0, 1, 0);
        check("R12 coalesced write no clear", {clr_readable, coal_valid}, 2'b01);
        send(MT, 32'hB000, 0, 0, 0, 1, 0);
        check("R12 maintenance miss clears", clr_readable, 1);
        check("R13 maintenance no notify", pf_notify, 0);
    endtask

    initial begin
        t_reset();
        t_hits();
        t_alloc_match();
        t_uncacheable();
        t_prefetch_evict();
        t_target_full();
        t_all_used();
        t_readable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule